// File: doc/BRIEF.md
# Two-Wire Serial Controller Control and Interrupt-Flag Unit

This block is the processor-side control logic of a byte-oriented two-wire serial controller. Software reaches it through a small register port holding a control register, a status register, a data register and an own-address register. A separate bus engine, which does the bit-level shifting, reports each finished bus event with a strobe and a five-bit status code. The unit then raises an event flag, and that flag holds the serial clock low until software has decided what to do next.

The flag drives the interrupt request, gated by a local enable bit and a global enable input. Software releases the bus by writing a one to the flag bit. A data-register write made while the engine owns the bus is refused and recorded as a write collision. START requests wait for the bus to become free before they are handed to the engine. STOP requests are cleared by hardware once the engine has sent them in master mode. In slave mode a STOP request sends nothing on the bus; it only returns the engine to the unaddressed slave state. Clearing the enable bit drops every pending request at once.

Top module: `twi_ctrl_unit`

## Requirements
- R1: After reset the control register reads 0x00, status 0xF8, data 0xFF, own-address 0xFE, and `irq`, `scl_hold`, `start_go`, `stop_go` and `slave_release` are low.
- R2: Register offsets are 0 control, 1 status, 2 data, 3 own-address. `reg_rdata` shows, one clock after the offset is presented, the value the register held before that edge. The control layout is: bit 7 event flag, 6 acknowledge enable, 5 START request, 4 STOP request, 3 write collision (read-only), 2 unit enable, 1 reserved (reads 0), 0 interrupt enable.
- R3: An `ev_set` strobe while the unit is enabled sets the flag and loads `ev_status` into status bits 7:3. Status bit 2 reads 0. Status bits 1:0 hold a prescaler that software can write, and it is driven on `prescale`.
- R4: Once set, the flag stays set until a control write with bit 7 = 1. Writing 0 to bit 7 has no effect. If a clearing write and an accepted event fall in the same cycle, the flag stays set.
- R5: `scl_hold` is high exactly while the flag is set and the unit is enabled. `irq` is high exactly while the flag, the interrupt-enable bit and `gie` are all set.
- R6: A data write while the flag is set stores the byte and clears the collision bit. A data write while the flag is clear sets the collision bit and leaves the data unchanged. `rx_valid` while enabled loads `rx_byte`, and it takes priority over a software data write in the same cycle.
- R7: `start_go` is high while the START bit is set, the unit is enabled, `bus_busy` is low, and no `start_done` has been seen since the bit was set. The START bit stays set until software clears it.
- R8: A STOP request written while `is_master` is high drives `stop_go` while the unit is enabled. The bit clears itself on `stop_done`.
- R9: A STOP request written while `is_master` is low is not kept. Instead, `slave_release` pulses for one cycle on the following cycle.
- R10: A control write with bit 2 = 0 clears the flag, START and STOP requests in that same edge. Events are ignored while the unit is disabled, so neither the flag nor the status changes.
- R11: Own-address register bits 7:1 drive `own_addr` and bit 0 drives `gc_en`. Control bit 6 drives `ack_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| gie | input | 1 | Global interrupt enable |
| ev_set | input | 1 | Bus engine event-finished strobe |
| ev_status | input | 5 | Status code for the event |
| rx_valid | input | 1 | Engine has shifted in a byte |
| rx_byte | input | 8 | Byte seen on the bus |
| bus_busy | input | 1 | Bus held by another master (between START and STOP) |
| is_master | input | 1 | Engine currently in master mode |
| start_done | input | 1 | Engine has sent the START |
| stop_done | input | 1 | Engine has sent the STOP |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Hold serial clock low |
| start_go | output | 1 | Request engine to send START |
| stop_go | output | 1 | Request engine to send STOP |
| slave_release | output | 1 | Return engine to unaddressed slave, release lines |
| unit_en | output | 1 | Unit enable |
| ack_en | output | 1 | Acknowledge enable |
| prescale | output | 2 | Bit-rate prescaler select |
| own_addr | output | 7 | Own slave address |
| gc_en | output | 1 | General-call recognition enable |

## Verification
The assertions check on every cycle the rules that depend only on recent history. These are: the flag persisting without a one-write, a refused data write leaving the byte untouched, the STOP and START requests dropping after the engine's done strobes, a slave-mode STOP never being latched, the disable write clearing all requests, and the reserved bit reading zero. Some behaviours can only be shown by the bench's scenarios. These include the precedence when a clearing write meets an event in the same cycle, the received byte winning over a software write, a START waiting out a busy bus and then firing, and the exact register values read back after each sequence.

// File: rtl/twi_ctrl_pkg.sv
// Package: shared widths, register offsets, control bit positions and reset values
// for the two-wire control unit. Assumes an 8-bit register file.
package twi_ctrl_pkg;
    localparam int DATA_W = 8;
    localparam int STAT_W = 5;
    localparam int PSC_W  = 2;
    localparam int ADDR_W = 2;
    localparam int SADR_W = DATA_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2,
        REG_SADR = 2'd3
    } reg_sel_e;

    // Control register bit positions (software decodes these)
    localparam int CB_FLAG = 7;
    localparam int CB_ACK  = 6;
    localparam int CB_STA  = 5;
    localparam int CB_STO  = 4;
    localparam int CB_WCOL = 3;
    localparam int CB_EN   = 2;
    localparam int CB_IE   = 0;

    localparam logic [STAT_W-1:0] STAT_RST = '1;
    localparam logic [DATA_W-1:0] DATA_RST = '1;
    localparam logic [DATA_W-1:0] SADR_RST = 8'hFE;
endpackage

// File: rtl/twi_flag_unit.sv
// Event flag and status code holder. Sets the flag on accepted engine events,
// clears it on a software one-write, drives clock hold and interrupt request.
// Assumes kill_i (disable write) and clr_i (flag one-write) are single-cycle.
module twi_flag_unit #(
    parameter int STAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              kill_i,
    input  logic              clr_i,
    input  logic              ev_i,
    input  logic [STAT_W-1:0] ev_status_i,
    input  logic              ie_i,
    input  logic              gie_i,
    output logic              flag_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o,
    output logic              scl_hold_o
);
    logic flag_q;
    logic [STAT_W-1:0] status_q;
    logic ev_ok;

    // Event accepted only while enabled and not being disabled this cycle
    assign ev_ok = en_i & ev_i & ~kill_i;

    // Flag update: disable beats event, event beats software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (kill_i) begin
            flag_q <= 1'b0;
        end else if (ev_ok) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    // Status code capture on each accepted event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= {STAT_W{1'b1}};
        end else if (ev_ok) begin
            status_q <= ev_status_i;
        end
    end

    assign flag_o     = flag_q;
    assign status_o   = status_q;
    assign scl_hold_o = flag_q & en_i;
    assign irq_o      = flag_q & ie_i & gie_i;

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !kill_i && !clr_i |=> flag_q);
    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ok |=> flag_q && (status_q == $past(ev_status_i)));
    assert_irq_needs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && en_i |-> scl_hold_o);
endmodule

// File: rtl/twi_data_unit.sv
// Data register with write-collision detection. Software writes are accepted
// only while the event flag is set; received bytes from the engine take priority.
module twi_data_unit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              flag_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic [DATA_W-1:0] data_o,
    output logic              wcol_o
);
    logic [DATA_W-1:0] data_q;
    logic wcol_q;
    logic rx_take;

    assign rx_take = en_i & rx_valid_i;

    // Data byte: engine load first, then an accepted software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= {DATA_W{1'b1}};
        end else if (rx_take) begin
            data_q <= rx_byte_i;
        end else if (wr_i && flag_i) begin
            data_q <= wdata_i;
        end
    end

    // Collision bit: set by a refused write, cleared by an accepted one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcol_q <= 1'b0;
        end else if (wr_i) begin
            wcol_q <= ~flag_i;
        end
    end

    assign data_o = data_q;
    assign wcol_o = wcol_q;

    assert_refused_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && !flag_i && !rx_take |=> wcol_q && $stable(data_q));
    assert_accepted_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && flag_i |=> !wcol_q);
endmodule

// File: rtl/twi_seq_unit.sv
// START/STOP request sequencer. START waits for a free bus and is offered once
// per request; STOP self-clears in master mode and becomes a slave release
// pulse in slave mode. Assumes done strobes are single-cycle.
module twi_seq_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic kill_i,
    input  logic wr_i,
    input  logic sta_wr_i,
    input  logic sto_wr_i,
    input  logic is_master_i,
    input  logic bus_busy_i,
    input  logic start_done_i,
    input  logic stop_done_i,
    output logic start_req_o,
    output logic stop_req_o,
    output logic start_go_o,
    output logic stop_go_o,
    output logic slave_rel_o
);
    logic start_q, sent_q, stop_q, rel_q;

    // START request bit: only software sets or clears it
    always_ff @(posedge clk) begin
        if (!rst_n)      start_q <= 1'b0;
        else if (kill_i) start_q <= 1'b0;
        else if (wr_i)   start_q <= sta_wr_i;
    end

    // Remembers that the engine already sent START for the current request
    always_ff @(posedge clk) begin
        if (!rst_n)                     sent_q <= 1'b0;
        else if (kill_i || !start_q)    sent_q <= 1'b0;
        else if (start_done_i && en_i)  sent_q <= 1'b1;
    end

    // STOP request bit: latched in master mode only, cleared when sent
    always_ff @(posedge clk) begin
        if (!rst_n)            stop_q <= 1'b0;
        else if (kill_i)       stop_q <= 1'b0;
        else if (wr_i)         stop_q <= sto_wr_i & is_master_i;
        else if (stop_done_i)  stop_q <= 1'b0;
    end

    // Slave-mode recovery pulse, one cycle after the STOP write
    always_ff @(posedge clk) begin
        if (!rst_n) rel_q <= 1'b0;
        else        rel_q <= wr_i & sto_wr_i & ~is_master_i & ~kill_i;
    end

    assign start_req_o = start_q;
    assign stop_req_o  = stop_q;
    assign start_go_o  = start_q & en_i & ~bus_busy_i & ~sent_q;
    assign stop_go_o   = stop_q & en_i;
    assign slave_rel_o = rel_q;

    assert_stop_selfclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q && stop_done_i && !wr_i && !kill_i |=> !stop_q);
    assert_start_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_go_o && start_done_i && !wr_i && !kill_i |=> !start_go_o && start_q);
    assert_slave_stop_not_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |-> !stop_q);
endmodule

// File: rtl/twi_ctrl_unit.sv
// Top: register port, control/own-address/prescaler fields and read-back mux
// for the two-wire control unit. Register accesses are synchronous; read data
// is registered and reflects state before the edge that captures it.
module twi_ctrl_unit
    import twi_ctrl_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = STAT_W,
    parameter int PW = PSC_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          gie,
    input  logic          ev_set,
    input  logic [SW-1:0] ev_status,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          bus_busy,
    input  logic          is_master,
    input  logic          start_done,
    input  logic          stop_done,
    output logic          irq,
    output logic          scl_hold,
    output logic          start_go,
    output logic          stop_go,
    output logic          slave_release,
    output logic          unit_en,
    output logic          ack_en,
    output logic [PW-1:0] prescale,
    output logic [DW-2:0] own_addr,
    output logic          gc_en
);
    localparam int RSV_W = DW - SW - PW;

    logic wr_ctrl, wr_stat, wr_data, wr_sadr, kill;
    logic en_q, ack_q, ie_q;
    logic [PW-1:0] psc_q;
    logic [DW-1:0] sadr_q;
    logic flag, wcol, start_req, stop_req;
    logic [SW-1:0] status;
    logic [DW-1:0] data;
    logic [DW-1:0] ctrl_view, stat_view, rdata_q;

    // Write decode per register offset
    always_comb begin
        wr_ctrl = reg_we && (reg_sel_e'(reg_addr) == REG_CTRL);
        wr_stat = reg_we && (reg_sel_e'(reg_addr) == REG_STAT);
        wr_data = reg_we && (reg_sel_e'(reg_addr) == REG_DATA);
        wr_sadr = reg_we && (reg_sel_e'(reg_addr) == REG_SADR);
    end

    assign kill = wr_ctrl & ~reg_wdata[CB_EN];

    // Plain control fields written directly by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ack_q <= 1'b0;
            ie_q  <= 1'b0;
        end else if (wr_ctrl) begin
            en_q  <= reg_wdata[CB_EN];
            ack_q <= reg_wdata[CB_ACK];
            ie_q  <= reg_wdata[CB_IE];
        end
    end

    // Prescaler field in the low bits of the status register
    always_ff @(posedge clk) begin
        if (!rst_n)       psc_q <= '0;
        else if (wr_stat) psc_q <= reg_wdata[PW-1:0];
    end

    // Own slave address and general-call enable
    always_ff @(posedge clk) begin
        if (!rst_n)       sadr_q <= SADR_RST;
        else if (wr_sadr) sadr_q <= reg_wdata;
    end

    twi_flag_unit #(.STAT_W(SW)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_q),
        .kill_i     (kill),
        .clr_i      (wr_ctrl & reg_wdata[CB_FLAG]),
        .ev_i       (ev_set),
        .ev_status_i(ev_status),
        .ie_i       (ie_q),
        .gie_i      (gie),
        .flag_o     (flag),
        .status_o   (status),
        .irq_o      (irq),
        .scl_hold_o (scl_hold)
    );

    twi_data_unit #(.DATA_W(DW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_q),
        .flag_i    (flag),
        .wr_i      (wr_data),
        .wdata_i   (reg_wdata),
        .rx_valid_i(rx_valid),
        .rx_byte_i (rx_byte),
        .data_o    (data),
        .wcol_o    (wcol)
    );

    twi_seq_unit u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_q),
        .kill_i      (kill),
        .wr_i        (wr_ctrl),
        .sta_wr_i    (reg_wdata[CB_STA]),
        .sto_wr_i    (reg_wdata[CB_STO]),
        .is_master_i (is_master),
        .bus_busy_i  (bus_busy),
        .start_done_i(start_done),
        .stop_done_i (stop_done),
        .start_req_o (start_req),
        .stop_req_o  (stop_req),
        .start_go_o  (start_go),
        .stop_go_o   (stop_go),
        .slave_rel_o (slave_release)
    );

    // Assemble the software views of control and status
    always_comb begin
        ctrl_view          = '0;
        ctrl_view[CB_FLAG] = flag;
        ctrl_view[CB_ACK]  = ack_q;
        ctrl_view[CB_STA]  = start_req;
        ctrl_view[CB_STO]  = stop_req;
        ctrl_view[CB_WCOL] = wcol;
        ctrl_view[CB_EN]   = en_q;
        ctrl_view[CB_IE]   = ie_q;
        stat_view          = {status, {RSV_W{1'b0}}, psc_q};
    end

    // Registered read-back of the addressed register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            case (reg_sel_e'(reg_addr))
                REG_CTRL: rdata_q <= ctrl_view;
                REG_STAT: rdata_q <= stat_view;
                REG_DATA: rdata_q <= data;
                default:  rdata_q <= sadr_q;
            endcase
        end
    end

    assign reg_rdata = rdata_q;
    assign unit_en   = en_q;
    assign ack_en    = ack_q;
    assign prescale  = psc_q;
    assign own_addr  = sadr_q[DW-1:1];
    assign gc_en     = sadr_q[0];

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && !reg_wdata[CB_EN] |=> !scl_hold && !start_go && !stop_go && !irq);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel_e'(reg_addr) == REG_CTRL |=> !reg_rdata[1]);
    assert_status_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel_e'(reg_addr) == REG_STAT |=> !reg_rdata[2]);
endmodule

// File: tb/tb_twi_ctrl_unit.sv
`timescale 1ns/1ps
module tb_twi_ctrl_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b1;
    logic       ev_set = 1'b0;
    logic [4:0] ev_status = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       bus_busy = 1'b0;
    logic       is_master = 1'b0;
    logic       start_done = 1'b0;
    logic       stop_done = 1'b0;
    logic       irq, scl_hold, start_go, stop_go, slave_release, unit_en, ack_en, gc_en;
    logic [1:0] prescale;
    logic [6:0] own_addr;

    always #2.5 clk = ~clk;

    twi_ctrl_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie), .ev_set(ev_set),
        .ev_status(ev_status), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .bus_busy(bus_busy), .is_master(is_master), .start_done(start_done),
        .stop_done(stop_done), .irq(irq), .scl_hold(scl_hold), .start_go(start_go),
        .stop_go(stop_go), .slave_release(slave_release), .unit_en(unit_en),
        .ack_en(ack_en), .prescale(prescale), .own_addr(own_addr), .gc_en(gc_en)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;
    bit  m_live = 0;

    // Behavioural reference state
    bit       m_flag, m_ack, m_sta, m_sto, m_wcol, m_en, m_ie, m_sent, m_rel;
    bit [4:0] m_stat;
    bit [1:0] m_psc;
    bit [7:0] m_data, m_sadr, m_rdata;

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] m_view(input bit [1:0] a);
        case (a)
            2'd0: m_view = {m_flag, m_ack, m_sta, m_sto, m_wcol, m_en, 1'b0, m_ie};
            2'd1: m_view = {m_stat, 1'b0, m_psc};
            2'd2: m_view = m_data;
            default: m_view = m_sadr;
        endcase
    endfunction

    task automatic m_reset();
        m_flag = 0; m_ack = 0; m_sta = 0; m_sto = 0; m_wcol = 0; m_en = 0; m_ie = 0;
        m_sent = 0; m_rel = 0; m_stat = 5'h1F; m_psc = 0; m_data = 8'hFF;
        m_sadr = 8'hFE; m_rdata = 8'h00;
    endtask

    // Reference model: one clock edge of the behaviour the requirements define
    task automatic m_step();
        bit wc, ws, wd, wa, kill, evok;
        bit [7:0] rd;
        rd   = m_view(reg_addr);
        wc   = reg_we && reg_addr == 2'd0;
        ws   = reg_we && reg_addr == 2'd1;
        wd   = reg_we && reg_addr == 2'd2;
        wa   = reg_we && reg_addr == 2'd3;
        kill = wc && !reg_wdata[2];
        evok = m_en && ev_set && !kill;
        m_rel = wc && reg_wdata[4] && !is_master && !kill;
        if (!m_sta || kill) m_sent = 0;
        else if (start_done && m_en) m_sent = 1;
        if (kill) m_sto = 0;
        else if (wc) m_sto = reg_wdata[4] && is_master;
        else if (stop_done) m_sto = 0;
        if (kill) m_sta = 0;
        else if (wc) m_sta = reg_wdata[5];
        if (m_en && rx_valid) m_data = rx_byte;
        else if (wd && m_flag) m_data = reg_wdata;
        if (wd) m_wcol = !m_flag;
        if (kill) m_flag = 0;
        else if (evok) m_flag = 1;
        else if (wc && reg_wdata[7]) m_flag = 0;
        if (evok) m_stat = ev_status;
        if (ws) m_psc = reg_wdata[1:0];
        if (wa) m_sadr = reg_wdata;
        if (wc) begin m_en = reg_wdata[2]; m_ack = reg_wdata[6]; m_ie = reg_wdata[0]; end
        m_rdata = rd;
    endtask

    // One cycle: compare outputs against the model, advance both, drop strobes
    task automatic tick();
        #1;
        if (m_live) begin
            chk("R2",  "rdata",         reg_rdata, m_rdata);
            chk("R5",  "irq",           {7'd0, irq}, {7'd0, m_flag && m_ie && gie});
            chk("R5",  "scl_hold",      {7'd0, scl_hold}, {7'd0, m_flag && m_en});
            chk("R7",  "start_go",      {7'd0, start_go}, {7'd0, m_sta && m_en && !bus_busy && !m_sent});
            chk("R8",  "stop_go",       {7'd0, stop_go}, {7'd0, m_sto && m_en});
            chk("R9",  "slave_release", {7'd0, slave_release}, {7'd0, m_rel});
            chk("R11", "ack_en",        {7'd0, ack_en}, {7'd0, m_ack});
            chk("R11", "own_addr",      {1'b0, own_addr}, {1'b0, m_sadr[7:1]});
            chk("R11", "gc_en",         {7'd0, gc_en}, {7'd0, m_sadr[0]});
            chk("R3",  "prescale",      {6'd0, prescale}, {6'd0, m_psc});
            chk("R10", "unit_en",       {7'd0, unit_en}, {7'd0, m_en});
        end
        @(posedge clk);
        if (!rst_n) begin m_reset(); m_live = 1; end
        else m_step();
        @(negedge clk);
        reg_we = 0; ev_set = 0; rx_valid = 0; start_done = 0; stop_done = 0;
    endtask

    task automatic wr(input bit [1:0] a, input bit [7:0] d);
        reg_addr = a; reg_we = 1; reg_wdata = d; tick();
    endtask

    task automatic expect_reg(input bit [1:0] a, input bit [7:0] e, input string tag);
        reg_addr = a; tick();
        chk(tag, "register readback", reg_rdata, e);
    endtask

    task automatic event_in(input bit [4:0] st);
        ev_set = 1; ev_status = st; tick();
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        // R1: reset values of every register
        expect_reg(2'd0, 8'h00, "R1");
        chk("R1", "irq after reset", {7'd0, irq}, 8'h00);
        expect_reg(2'd1, 8'hF8, "R1");
        expect_reg(2'd2, 8'hFF, "R1");
        expect_reg(2'd3, 8'hFE, "R1");

        // R10: events ignored while disabled
        event_in(5'h03);
        expect_reg(2'd1, 8'hF8, "R10");

        // R2: enable and interrupt enable, layout readback
        wr(2'd0, 8'h05);
        expect_reg(2'd0, 8'h05, "R2");
        // R2/R9: all-ones write in slave mode; reserved and collision read 0, STOP not kept
        wr(2'd0, 8'hFF);
        chk("R9", "slave_release pulse", {7'd0, slave_release}, 8'h01);
        expect_reg(2'd0, 8'h65, "R2");
        wr(2'd0, 8'h05);

        // R6: refused data write with flag low
        wr(2'd2, 8'h3C);
        expect_reg(2'd0, 8'h0D, "R6");
        expect_reg(2'd2, 8'hFF, "R6");

        // R3: event sets flag and status
        event_in(5'h08);
        chk("R5", "irq with flag", {7'd0, irq}, 8'h01);
        expect_reg(2'd1, 8'h40, "R3");
        expect_reg(2'd0, 8'h8D, "R3");
        // R4: writing zero to the flag bit has no effect
        wr(2'd0, 8'h05);
        expect_reg(2'd0, 8'h8D, "R4");
        // R6: accepted write clears collision
        wr(2'd2, 8'hA5);
        expect_reg(2'd2, 8'hA5, "R6");
        expect_reg(2'd0, 8'h85, "R6");
        // R3: prescaler write
        wr(2'd1, 8'hFF);
        expect_reg(2'd1, 8'h43, "R3");
        // R4: same-cycle clear and event, event wins
        reg_addr = 2'd0; reg_we = 1; reg_wdata = 8'h85; ev_set = 1; ev_status = 5'h10; tick();
        expect_reg(2'd0, 8'h85, "R4");
        expect_reg(2'd1, 8'h83, "R4");
        wr(2'd0, 8'h85);
        expect_reg(2'd0, 8'h05, "R4");

        // R5: global enable low masks the request
        gie = 0;
        event_in(5'h0A);
        chk("R5", "irq masked by gie", {7'd0, irq}, 8'h00);
        chk("R5", "hold still set", {7'd0, scl_hold}, 8'h01);
        gie = 1; tick();
        wr(2'd0, 8'h85);

        // R6: received byte loads data; beats a same-cycle software write
        rx_valid = 1; rx_byte = 8'h5A; tick();
        expect_reg(2'd2, 8'h5A, "R6");
        reg_addr = 2'd2; reg_we = 1; reg_wdata = 8'h22; rx_valid = 1; rx_byte = 8'h11; tick();
        expect_reg(2'd2, 8'h11, "R6");
        expect_reg(2'd0, 8'h0D, "R6");

        // R7: START waits for a free bus, fires once, bit stays
        bus_busy = 1;
        wr(2'd0, 8'h25);
        tick(); tick();
        chk("R7", "start_go while busy", {7'd0, start_go}, 8'h00);
        bus_busy = 0; tick();
        chk("R7", "start_go when free", {7'd0, start_go}, 8'h01);
        start_done = 1; tick();
        chk("R7", "start_go after done", {7'd0, start_go}, 8'h00);
        expect_reg(2'd0, 8'h2D, "R7");
        wr(2'd0, 8'h05);

        // R8: STOP in master mode, self-clear
        is_master = 1;
        wr(2'd0, 8'h15);
        chk("R8", "stop_go", {7'd0, stop_go}, 8'h01);
        tick();
        stop_done = 1; tick();
        chk("R8", "stop_go after done", {7'd0, stop_go}, 8'h00);
        expect_reg(2'd0, 8'h0D, "R8");
        is_master = 0;

        // R10: disable write clears flag and requests
        event_in(5'h0B);
        bus_busy = 1;
        wr(2'd0, 8'h75);
        wr(2'd0, 8'h00);
        expect_reg(2'd0, 8'h08, "R10");
        chk("R10", "scl_hold off", {7'd0, scl_hold}, 8'h00);
        bus_busy = 0;

        // R11: own address register
        wr(2'd3, 8'h43);
        chk("R11", "own_addr", {1'b0, own_addr}, 8'h21);
        expect_reg(2'd3, 8'h43, "R11");

        // Re-enable with acknowledge and run a final mixed pattern
        wr(2'd0, 8'h45);
        chk("R11", "ack_en", {7'd0, ack_en}, 8'h01);
        for (int i = 0; i < 20; i++) begin
            reg_addr = 2'(i);
            ev_set = (i % 5 == 0);
            ev_status = 5'(i);
            tick();
            if (i % 5 == 2) wr(2'd0, 8'hC5);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule